// File: doc/BRIEF.md
# Instruction Opcode Register with Interrupt Override

This block holds the three-bit basic opcode of the instruction being executed by a 12-bit minicomputer CPU. In the fetch cycle, at the second timing pulse of the second time state, it takes the three top bits of the memory-data word. In the fourth time state it either keeps its value or takes the subroutine-call (JMS) opcode. It takes JMS when the interrupt logic raised its in-progress flag at the third timing pulse of that state. That override is how a honoured interrupt turns the final cycle of any instruction into a forced subroutine call.

The opcode leaves the block on active-low lines, each the complement of one opcode bit. A separate enable input hands the lines over to a DMA transfer. While the enable is low, every line sits at its inactive level (all ones) and a valid flag drops. The stored opcode is still held underneath, so the interrupted instruction resumes with its opcode once the enable returns. The register keeps loading while the lines are disabled, so a JMS forced in the same pulse that starts a DMA transfer appears after that transfer.

Top module: `instr_reg_top`

## Requirements
- R1: A synchronous active-high reset loads the OPR code (7) and clears any sampled interrupt. With the enable high, the lines then read 3'b000.
- R2: Opcode codes are AND=0, TAD=1, ISZ=2, DCA=3, JMS=4, JMP=5, IOT=6, OPR=7. In the cycle with `ts2` and `tp2` both high and `mstate` equal to fetch (2'd0), the register loads `md_op`, with `md_op[2]` as the most significant bit.
- R3: The major-state encoding is fetch=0, defer=1, execute=2, DMA=3. A `ts2`/`tp2` strobe in any state other than fetch leaves the register unchanged.
- R4: The interrupt flag is sampled only in the cycle where `ts4`, `tp3` and `int_in_prog` are all high. Once it has been sampled, the next cycle with `ts4` and `tp4` both high loads JMS (4).
- R5: A `ts4`/`tp4` strobe with no sampled interrupt leaves the register unchanged.
- R6: Any cycle with `tp4` high discards the sampled interrupt. `int_in_prog` raised only during `tp4`, or outside `ts4`, forces nothing.
- R7: The forced JMS works the same in the fetch, defer and execute states.
- R8: With `ir_en` low, `ir_n` is 3'b111 and `ir_valid` is low. The stored opcode is kept and reappears unchanged once `ir_en` returns high.
- R9: A JMS forced while `ir_en` is low is stored, and shows once `ir_en` is high again.
- R10: With `ir_en` high, `ir_valid` is high and `ir_n` is the bitwise complement of the stored opcode.
- R11: A timing pulse outside its own time state (`tp2` without `ts2`, `tp4` without `ts4`) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts2 | input | 1 | Second time state active |
| ts4 | input | 1 | Fourth time state active |
| tp2 | input | 1 | Second timing pulse (one cycle) |
| tp3 | input | 1 | Third timing pulse (one cycle) |
| tp4 | input | 1 | Fourth timing pulse (one cycle) |
| mstate | input | 2 | Major state: 0 fetch, 1 defer, 2 execute, 3 DMA |
| md_op | input | 3 | Memory-data bits 0..2 in true logic, bit 2 most significant |
| int_in_prog | input | 1 | Interrupt honoured by the interrupt logic |
| ir_en | input | 1 | Major-state/opcode output enable, high drives the lines |
| ir_n | output | 3 | Active-low opcode lines, all ones when disabled |
| ir_valid | output | 1 | High while the lines carry the opcode |

## Verification
All eight opcode values are loaded through the fetch strobe, so each bit of the line inversion is checked in both polarities. Load strobes are then given in the defer and execute states and with pulses outside their time states, which separates the fetch-only load condition from a plain pulse decode. The interrupt is raised at the third pulse in each of the three states and also only at the fourth pulse, which tells a properly sampled flag from a live one. Finally, the enable is dropped with and without a forced JMS, which shows that hiding the output does not disturb the stored value.

// File: rtl/ir_pkg.sv
package ir_pkg;
    localparam int OP_W  = 3;
    localparam int MS_W  = 2;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 3'd0,
        OP_TAD = 3'd1,
        OP_ISZ = 3'd2,
        OP_DCA = 3'd3,
        OP_JMS = 3'd4,
        OP_JMP = 3'd5,
        OP_IOT = 3'd6,
        OP_OPR = 3'd7
    } opcode_e;

    typedef enum logic [MS_W-1:0] {
        MS_FETCH = 2'd0,
        MS_DEFER = 2'd1,
        MS_EXEC  = 2'd2,
        MS_DMA   = 2'd3
    } mstate_e;

    localparam opcode_e RESET_OP = OP_OPR;
    localparam opcode_e FORCE_OP = OP_JMS;

    typedef struct packed {
        logic ts2;
        logic ts4;
        logic tp2;
        logic tp3;
        logic tp4;
    } timing_t;

    typedef struct packed {
        logic    load;
        opcode_e value;
    } next_op_t;

    function automatic logic [OP_W-1:0] drive_lines(opcode_e op, logic en);
        return en ? ~op : {OP_W{1'b1}};
    endfunction
endpackage

// File: rtl/ir_int_sample.sv
module ir_int_sample
    import ir_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  timing_t tim,
    input  logic    int_in_prog,
    output logic    int_seen
);
    logic sample_now;
    assign sample_now = tim.ts4 && tim.tp3 && int_in_prog;

    always_ff @(posedge clk) begin
        if (rst)
            int_seen <= 1'b0;
        else if (sample_now)
            int_seen <= 1'b1;
        else if (tim.tp4)
            int_seen <= 1'b0;
    end
endmodule

// File: rtl/ir_next_sel.sv
module ir_next_sel
    import ir_pkg::*;
(
    input  timing_t           tim,
    input  mstate_e           ms,
    input  logic [OP_W-1:0]   md_op,
    input  logic              int_seen,
    output next_op_t          nxt
);
    logic take_memory;
    logic take_force;

    assign take_memory = tim.ts2 && tim.tp2 && (ms == MS_FETCH);
    assign take_force  = tim.ts4 && tim.tp4 && int_seen;

    always_comb begin
        nxt.load  = 1'b0;
        nxt.value = opcode_e'(md_op);
        if (take_force) begin
            nxt.load  = 1'b1;
            nxt.value = FORCE_OP;
        end else if (take_memory) begin
            nxt.load  = 1'b1;
        end
    end
endmodule

// File: rtl/ir_store.sv
module ir_store
    import ir_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  next_op_t nxt,
    output opcode_e  op_q
);
    always_ff @(posedge clk) begin
        if (rst)
            op_q <= RESET_OP;
        else if (nxt.load)
            op_q <= nxt.value;
    end
endmodule

// File: rtl/ir_line_drv.sv
module ir_line_drv
    import ir_pkg::*;
(
    input  opcode_e          op_q,
    input  logic             en,
    output logic [OP_W-1:0]  lines_n,
    output logic             valid
);
    logic [OP_W-1:0] inv;
    assign inv = drive_lines(op_q, 1'b1);

    for (genvar b = 0; b < OP_W; b++) begin : g_line
        assign lines_n[b] = en ? inv[b] : 1'b1;
    end

    assign valid = en;
endmodule

// File: rtl/instr_reg_top.sv
module instr_reg_top
    import ir_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ts2,
    input  logic              ts4,
    input  logic              tp2,
    input  logic              tp3,
    input  logic              tp4,
    input  logic [MS_W-1:0]   mstate,
    input  logic [OP_W-1:0]   md_op,
    input  logic              int_in_prog,
    input  logic              ir_en,
    output logic [OP_W-1:0]   ir_n,
    output logic              ir_valid
);
    timing_t  tim;
    mstate_e  ms;
    logic     int_seen;
    next_op_t nxt;
    opcode_e  op_q;

    assign tim = '{ts2: ts2, ts4: ts4, tp2: tp2, tp3: tp3, tp4: tp4};
    assign ms  = mstate_e'(mstate);

    ir_int_sample u_sample (
        .clk         (clk),
        .rst         (rst),
        .tim         (tim),
        .int_in_prog (int_in_prog),
        .int_seen    (int_seen)
    );

    ir_next_sel u_sel (
        .tim      (tim),
        .ms       (ms),
        .md_op    (md_op),
        .int_seen (int_seen),
        .nxt      (nxt)
    );

    ir_store u_store (
        .clk  (clk),
        .rst  (rst),
        .nxt  (nxt),
        .op_q (op_q)
    );

    ir_line_drv u_drv (
        .op_q    (op_q),
        .en      (ir_en),
        .lines_n (ir_n),
        .valid   (ir_valid)
    );
endmodule

// File: rtl/ir_reg_checker.sv
module ir_reg_checker (
    input logic       clk,
    input logic       rst,
    input logic       ts2,
    input logic       ts4,
    input logic       tp2,
    input logic       tp3,
    input logic       tp4,
    input logic [1:0] mstate,
    input logic [2:0] md_op,
    input logic       int_in_prog,
    input logic       ir_en,
    input logic [2:0] ir_n,
    input logic       ir_valid,
    input logic [2:0] op_q,
    input logic       int_seen
);
    AST_RESET_OPR: assert property (@(posedge clk)
        rst |=> (op_q == 3'd7 && !int_seen)); // R1

    AST_FETCH_LOAD: assert property (@(posedge clk) disable iff (rst)
        (ts2 && tp2 && mstate == 2'd0 && !(ts4 && tp4 && int_seen))
        |=> (op_q == $past(md_op))); // R2

    AST_FORCE_JMS: assert property (@(posedge clk) disable iff (rst)
        (ts4 && tp4 && int_seen) |=> (op_q == 3'd4)); // R4

    AST_HOLD_OTHERWISE: assert property (@(posedge clk) disable iff (rst)
        (!(ts2 && tp2 && mstate == 2'd0) && !(ts4 && tp4 && int_seen))
        |=> $stable(op_q)); // R5

    AST_SAMPLE_ONLY_TP3: assert property (@(posedge clk) disable iff (rst)
        (!int_seen && !(ts4 && tp3 && int_in_prog)) |=> !int_seen); // R6

    AST_DISABLED_LINES: assert property (@(posedge clk) disable iff (rst)
        !ir_en |-> (ir_n == 3'b111 && !ir_valid)); // R8

    AST_ENABLED_LINES: assert property (@(posedge clk) disable iff (rst)
        ir_en |-> (ir_valid && ir_n == ~op_q)); // R10
endmodule

bind instr_reg_top ir_reg_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .ts2         (ts2),
    .ts4         (ts4),
    .tp2         (tp2),
    .tp3         (tp3),
    .tp4         (tp4),
    .mstate      (mstate),
    .md_op       (md_op),
    .int_in_prog (int_in_prog),
    .ir_en       (ir_en),
    .ir_n        (ir_n),
    .ir_valid    (ir_valid),
    .op_q        (op_q),
    .int_seen    (int_seen)
);

// File: tb/instr_reg_top_test.sv
`timescale 1ns/1ps
module instr_reg_top_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       ts2, ts4, tp2, tp3, tp4;
    logic [1:0] mstate;
    logic [2:0] md_op;
    logic       int_in_prog;
    logic       ir_en;
    logic [2:0] ir_n;
    logic       ir_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    int m_op;
    bit m_armed;

    always #2.5 clk = ~clk;

    instr_reg_top uut (
        .clk(clk), .rst(rst), .ts2(ts2), .ts4(ts4), .tp2(tp2), .tp3(tp3),
        .tp4(tp4), .mstate(mstate), .md_op(md_op), .int_in_prog(int_in_prog),
        .ir_en(ir_en), .ir_n(ir_n), .ir_valid(ir_valid)
    );

    task automatic quiet();
        ts2 = 0; ts4 = 0; tp2 = 0; tp3 = 0; tp4 = 0; int_in_prog = 0; rst = 0;
    endtask

    task automatic check(string tag, logic [2:0] got_n, logic got_v,
                         logic [2:0] exp_n, logic exp_v);
        checks++;
        if (got_n !== exp_n || got_v !== exp_v) begin
            fails++;
            $display("FAIL %s: ir_n=%b valid=%b expected ir_n=%b valid=%b",
                     tag, got_n, got_v, exp_n, exp_v);
        end
    endtask

    // one clock: advance reference model, then compare outputs
    task automatic cyc(string tag);
        bit force_now, load_now;
        @(posedge clk);
        if (rst) begin
            m_op = 7; m_armed = 0;
        end else begin
            force_now = ts4 && tp4 && m_armed;
            load_now  = ts2 && tp2 && (mstate == 2'd0);
            if (force_now) m_op = 4;
            else if (load_now) m_op = int'(md_op);
            if (ts4 && tp3 && int_in_prog) m_armed = 1;
            else if (tp4) m_armed = 0;
        end
        #1;
        if (ir_en) check(tag, ir_n, ir_valid, 3'(7 - m_op), 1'b1);
        else       check(tag, ir_n, ir_valid, 3'b111, 1'b0);
    endtask

    task automatic fetch_load(string tag, logic [2:0] v);
        mstate = 2'd0; md_op = v; ts2 = 1; tp2 = 1;
        cyc(tag);
        quiet();
    endtask

    // TS4 with optional interrupt at TP3, then TP4
    task automatic ts4_pass(string tag, logic [1:0] ms, bit irq_tp3, bit irq_tp4);
        mstate = ms; ts4 = 1;
        tp3 = 1; int_in_prog = irq_tp3; cyc(tag);
        tp3 = 0; int_in_prog = 0;       cyc(tag);
        tp4 = 1; int_in_prog = irq_tp4; cyc(tag);
        quiet();
    endtask

    initial begin
        quiet(); mstate = 0; md_op = 0; ir_en = 1;
        m_op = 0; m_armed = 0;
        rst = 1;
        cyc("R1"); cyc("R1");
        rst = 0;
        cyc("R1");

        // R2 / R10: every opcode value through fetch
        for (int v = 0; v < 8; v++) begin
            fetch_load("R2", 3'(v));
            cyc("R10");
        end

        // R3: load strobe outside fetch
        fetch_load("R2", 3'd1);
        mstate = 2'd1; md_op = 3'd6; ts2 = 1; tp2 = 1; cyc("R3"); quiet();
        mstate = 2'd2; md_op = 3'd5; ts2 = 1; tp2 = 1; cyc("R3"); quiet();
        mstate = 2'd3; md_op = 3'd0; ts2 = 1; tp2 = 1; cyc("R3"); quiet();

        // R11: pulses outside their time states
        mstate = 2'd0; md_op = 3'd2; tp2 = 1; cyc("R11"); quiet();
        mstate = 2'd0; md_op = 3'd2; ts2 = 1; cyc("R11"); quiet();
        tp3 = 1; int_in_prog = 1; cyc("R11"); quiet();
        tp4 = 1; cyc("R11"); quiet();

        // R5: TS4 without interrupt
        fetch_load("R2", 3'd3);
        ts4_pass("R5", 2'd0, 0, 0);

        // R6: interrupt only at TP4
        ts4_pass("R6", 2'd2, 0, 1);

        // R4 / R7: forced JMS from each non-DMA state
        fetch_load("R2", 3'd1);
        ts4_pass("R4", 2'd0, 1, 0);
        fetch_load("R2", 3'd3);
        ts4_pass("R7", 2'd1, 1, 0);
        fetch_load("R2", 3'd2);
        ts4_pass("R7", 2'd2, 1, 1);

        // R6: sampled flag discarded by a TP4 outside TS4
        fetch_load("R2", 3'd6);
        mstate = 2'd2; ts4 = 1; tp3 = 1; int_in_prog = 1; cyc("R6"); quiet();
        tp4 = 1; cyc("R6"); quiet();
        ts4 = 1; tp4 = 1; cyc("R6"); quiet();

        // R8: disable keeps stored value
        fetch_load("R2", 3'd5);
        ir_en = 0; cyc("R8"); cyc("R8");
        ts4_pass("R8", 2'd3, 0, 0);
        ir_en = 1; cyc("R8");

        // R9: force while disabled
        fetch_load("R2", 3'd7);
        ir_en = 0;
        ts4_pass("R9", 2'd2, 1, 0);
        cyc("R9");
        ir_en = 1; cyc("R9");

        // R1: reset from non-OPR value with armed interrupt
        fetch_load("R2", 3'd0);
        ts4 = 1; tp3 = 1; int_in_prog = 1; cyc("R1"); quiet();
        rst = 1; cyc("R1"); rst = 0;
        ts4 = 1; tp4 = 1; cyc("R1"); quiet();

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #50000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule